// File: doc/BRIEF.md
# Sequential Radix-4 Signed Multiplier with Early Termination

This block multiplies two 32-bit two's-complement operands over several clock cycles and returns the low 32 bits of their signed product. It is meant for the execution unit of a small processor core, next to single-cycle arithmetic. Multiply is one of the few operations there that take several cycles, and its latency depends on the operand values.

Each cycle the block takes two multiplier bits. It forms a radix-4 signed digit from a three-bit window that shares its lowest bit with the previous window. It adds zero, plus or minus the multiplicand, or plus or minus twice the multiplicand into an accumulator, then moves on by two bit positions. Before each step it tests whether the bits not yet scanned, together with the last scanned bit, are all equal. If they are, every remaining digit is zero and the block stops. A small multiplier therefore finishes in a few cycles. A start strobe loads the operands. A busy flag covers the operation, and a one-cycle done pulse marks the cycle in which the registered product becomes valid.

Top module: `booth_mul`

## Requirements
- R1: While reset is high and in the first cycle after it, busy is 0, done is 0 and product is 0.
- R2: When done is 1, product equals the low 32 bits of the two's-complement product of the multiplicand and multiplier captured by the accepted start.
- R3: Step i uses the multiplier bits {b[2i+1], b[2i], b[2i-1]}, with b[-1] taken as 0. It adds 0 for 000 and 111, +M for 001 and 010, +2M for 011, -2M for 100 and -M for 101 and 110, each weighted by 4^i. For example, a multiplier of 2 is formed as -2M followed by +4M.
- R4: One step is taken per clock and at most 16 steps are taken. Done is seen k+1 clock edges after the edge that accepts start, where k is the number of steps taken. The worst case (k = 16) is 17 edges.
- R5: The block stops before step i once multiplier bits b[31] down to b[2i-1] are all equal. Step 0 tests b together with a 0 below it. So k = 0 only for a multiplier of 0, and k = 1 for the multipliers -2, -1 and 1.
- R6: Busy is 1 from the edge that accepts start up to the edge that raises done. At that edge busy falls. Done is a single-cycle pulse.
- R7: A start that arrives while busy is 1 is ignored: the running operation keeps its operands, its product and its latency, and no new operation begins after it.
- R8: Product holds its value from one completion to the next, whatever the operand inputs do in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiply; accepted only when busy is 0 |
| mcand_in | input | 32 | Multiplicand, two's complement |
| mplier_in | input | 32 | Multiplier, two's complement |
| product | output | 32 | Low 32 bits of the signed product, registered |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: product has just been updated |

## Verification
The assertions check, on every cycle, the handshake of busy and done. They also check that a detected uniform tail ends the operation on the next edge, and that the step count never passes 16 and forces termination at 16. Finally they check that the operands stay frozen while busy and that product moves only with done. Only the bench scenarios can show that the arithmetic is right and that the latency matches the early-out rule for each multiplier. These scenarios cover zero, small positive and negative values, the most negative value, wrap-around, and a bit pattern that forces all 16 steps. The bench also shows that a start during an operation is ignored.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [2:0] {
    DIG_ZERO = 3'd0,
    DIG_POS1 = 3'd1,
    DIG_POS2 = 3'd2,
    DIG_NEG1 = 3'd3,
    DIG_NEG2 = 3'd4
  } booth_digit_e;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic [2:0]   window,
  output booth_digit_e digit
);
  always_comb begin
    unique case (window)
      3'b001, 3'b010: digit = DIG_POS1;
      3'b011:         digit = DIG_POS2;
      3'b100:         digit = DIG_NEG2;
      3'b101, 3'b110: digit = DIG_NEG1;
      default:        digit = DIG_ZERO;
    endcase
  end
endmodule

// File: rtl/booth_addend.sv
module booth_addend
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  booth_digit_e     digit,
  input  logic [WIDTH-1:0] mshift,
  output logic [WIDTH-1:0] addend
);
  logic [WIDTH-1:0] m_x2;
  assign m_x2 = {mshift[WIDTH-2:0], 1'b0};

  always_comb begin
    unique case (digit)
      DIG_POS1: addend = mshift;
      DIG_POS2: addend = m_x2;
      DIG_NEG1: addend = ~mshift + WIDTH'(1);
      DIG_NEG2: addend = ~m_x2 + WIDTH'(1);
      default:  addend = '0;
    endcase
  end
endmodule

// File: rtl/booth_eo_detect.sv
module booth_eo_detect #(
  parameter int BITS = 33
) (
  input  logic [BITS-1:0] tail,
  output logic            uniform
);
  assign uniform = (&tail) | ~(|tail);
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] mcand_in,
  input  logic [WIDTH-1:0] mplier_in,
  output logic [WIDTH-1:0] product,
  output logic             busy,
  output logic             done
);
  localparam int STEPS = WIDTH / 2;
  localparam int CW    = $clog2(STEPS + 1);

  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] mshift_q;
  logic [WIDTH-1:0] mplier_q;
  logic             prev_q;
  logic [CW-1:0]    step_q;

  booth_digit_e     digit;
  logic [WIDTH-1:0] addend;
  logic             tail_uniform;

  booth_recoder u_rec (
    .window ({mplier_q[1:0], prev_q}),
    .digit  (digit)
  );

  booth_addend #(.WIDTH(WIDTH)) u_add (
    .digit  (digit),
    .mshift (mshift_q),
    .addend (addend)
  );

  booth_eo_detect #(.BITS(WIDTH + 1)) u_eo (
    .tail    ({mplier_q, prev_q}),
    .uniform (tail_uniform)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      mshift_q <= '0;
      mplier_q <= '0;
      prev_q   <= 1'b0;
      step_q   <= '0;
      product  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          acc_q    <= '0;
          mshift_q <= mcand_in;
          mplier_q <= mplier_in;
          prev_q   <= 1'b0;
          step_q   <= '0;
        end
      end else if (tail_uniform) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        product <= acc_q;
      end else begin
        acc_q    <= acc_q + addend;
        mshift_q <= {mshift_q[WIDTH-3:0], 2'b00};
        mplier_q <= {{2{mplier_q[WIDTH-1]}}, mplier_q[WIDTH-1:2]};
        prev_q   <= mplier_q[1];
        step_q   <= step_q + CW'(1);
      end
    end
  end

  // Done only ends a running operation, and busy is already low by then.
  assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // A uniform tail seen while busy ends the operation on the next edge.
  assert_early_out_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && tail_uniform) |=> (done && !busy));

  assert_step_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (step_q <= CW'(STEPS)));

  assert_last_step_stops_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && step_q == CW'(STEPS)) |-> tail_uniform);

  // Operands in flight cannot be replaced by a second start.
  assert_ignore_start_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $past(start)) |-> ($past(step_q) + CW'(1) == step_q));

  assert_product_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));
endmodule

// File: tb/tb_booth_mul.sv
module tb_booth_mul;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [W-1:0] mcand_in;
  logic [W-1:0] mplier_in;
  logic [W-1:0] product;
  logic         busy;
  logic         done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_mul #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .start(start),
    .mcand_in(mcand_in), .mplier_in(mplier_in),
    .product(product), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Steps taken under the early-out rule, computed from the multiplier bits.
  function automatic int exp_steps(input logic [W-1:0] b);
    if (b == '0) return 0;
    for (int k = 1; k <= W/2; k++) begin
      bit same = 1'b1;
      for (int i = 2*k-1; i < W; i++) if (b[i] != b[W-1]) same = 1'b0;
      if (same) return k;
    end
    return W/2;
  endfunction

  // Launch one multiply; optionally pulse start again mid-run with other operands.
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                         input string req, input int restart_at);
    logic [W-1:0] exp_p;
    int cycles;
    bit busy_gap;
    exp_p = a * b;
    @(negedge clk);
    mcand_in = a; mplier_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R6", "busy after start", {busy, done}, 2'b10);
    cycles = 0;
    busy_gap = 1'b0;
    while (!done && cycles < 40) begin
      if (cycles == restart_at) begin
        mcand_in = ~a; mplier_in = 32'h0000_0003; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cycles++;
      if (!done && !busy) busy_gap = 1'b1;
    end
    chk(done, req, "done seen", done, 1);
    chk(!busy_gap, "R6", "busy held until done", busy_gap, 0);
    chk(!busy, "R6", "busy low with done", busy, 0);
    chk(product == exp_p, "R2", $sformatf("product %0h*%0h", a, b), product, exp_p);
    chk(cycles == exp_steps(b) + 1, "R4", $sformatf("latency mplier %0h", b),
        cycles, exp_steps(b) + 1);
    @(negedge clk);
    chk(!done, "R6", "done single pulse", done, 0);
    chk(!busy, "R7", "no new operation after run", busy, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1; start = 1'b0; mcand_in = '0; mplier_in = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && product == '0, "R1", "in reset", {busy, done, product}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && product == '0, "R1", "after reset", {busy, done, product}, 0);
  endtask

  task automatic t_basic;
    run_mul(32'd7, 32'd6, "R2", -1);
    run_mul(32'hFFFF_FFF9, 32'd5, "R2", -1);
    run_mul(32'd123456, 32'hFFFF_FC00, "R2", -1);
    run_mul(32'h8000_0000, 32'h8000_0000, "R2", -1);
    run_mul(32'h1234_5678, 32'h9ABC_DEF0, "R2", -1);
    run_mul(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R2", -1);
  endtask

  task automatic t_recode_R3;
    run_mul(32'd1000, 32'd2, "R3", -1);
    run_mul(32'd1000, 32'd3, "R3", -1);
    run_mul(32'd1000, 32'hFFFF_FFFD, "R3", -1);
    run_mul(32'd1000, 32'h5555_5555, "R3", -1);
    run_mul(32'd1000, 32'hAAAA_AAAA, "R3", -1);
  endtask

  task automatic t_early_out_R5;
    run_mul(32'hDEAD_BEEF, 32'd0, "R5", -1);
    run_mul(32'hDEAD_BEEF, 32'hFFFF_FFFF, "R5", -1);
    run_mul(32'hDEAD_BEEF, 32'd1, "R5", -1);
    run_mul(32'hDEAD_BEEF, 32'hFFFF_FFFE, "R5", -1);
    run_mul(32'h0000_0011, 32'h0000_0100, "R5", -1);
  endtask

  task automatic t_max_latency_R4;
    run_mul(32'd9, 32'h4000_0000, "R4", -1);
    run_mul(32'd9, 32'hBFFF_FFFF, "R4", -1);
  endtask

  task automatic t_start_busy_R7;
    run_mul(32'd7, 32'h4000_0000, "R7", 3);
    run_mul(32'hFFFF_0001, 32'h0012_3456, "R7", 0);
  endtask

  task automatic t_hold_R8;
    logic [W-1:0] held;
    run_mul(32'd21, 32'd2, "R8", -1);
    held = product;
    for (int i = 0; i < 6; i++) begin
      mcand_in = 32'hA5A5_0000 + i; mplier_in = 32'h0F0F_0000 - i;
      @(negedge clk);
    end
    chk(product == held, "R8", "product held", product, held);
    chk(!busy, "R8", "idle without start", busy, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_recode_R3();
    t_early_out_R5();
    t_max_latency_R4();
    t_start_busy_R7();
    t_hold_R8();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule